// File: doc/BRIEF.md
# Processor Interrupt Delivery Unit

This block sits between the interrupt sources of a system and a single processor core. It holds three kinds of request until the core reaches an instruction boundary: a reset request, a non-maskable request, and a 6-bit level word from the interrupt controller. A reset or non-maskable request arrives as a one-cycle pulse. A level word arrives with a write strobe. At each boundary the unit services at most one held request, in a fixed priority order. It updates the hardware-pending field it presents to the core's cause register, and it raises one of two exception pulses.

A level word of zero marks the end of an interrupt. When it is serviced it clears the cause pending field and raises no exception. The core supplies the global interrupt enable and the 6-bit mask from its status register. A nonzero level that is disabled or masked stays held. The unit tries it again at every later boundary until the level is accepted or replaced.

Top module: `irq_delivery_unit`

## Requirements
- R1: When several requests are held at a boundary, the reset request is serviced first, then the non-maskable request, then the level. Only one request is serviced per boundary. A held level is not examined, and the cause field does not change, at a boundary that services reset or the non-maskable request.
- R2: A held reset request or a held non-maskable request raises `exc_nmi_rst_o` in the cycle of the servicing boundary. The serviced flag is then cleared, so a later boundary with nothing held raises no exception.
- R3: When a nonzero level is serviced, `cause_hwpend_o` holds that level, truncated to 6 bits, from the next cycle onward. This happens whether or not the exception fires.
- R4: When a zero level (the end-of-interrupt marker) is serviced, `cause_hwpend_o` becomes 0 in the next cycle and no exception is raised. The level then returns to idle, so later boundaries raise no interrupt whatever the enable and mask are.
- R5: `exc_int_o` pulses at a servicing boundary only when `sr_ie_i` is 1 and the held level ANDed bitwise with `sr_mask_i` is nonzero. After it fires, the level is no longer held.
- R6: A nonzero level that is disabled or masked stays held and is tried again at every following boundary. It is taken once the enable and mask allow it, with no new level write.
- R7: A request is captured at the clock edge. It is delivered at the first cycle with `insn_bnd_i` high after that edge. A request given in the same cycle as a boundary waits for the next boundary. Without a boundary no exception is raised.
- R8: A new level write replaces any held level, including a held end-of-interrupt marker. Only the last value written is serviced.
- R9: While `rst_n` is low, all held requests, the held level and `cause_hwpend_o` are cleared, and both exception outputs are 0.
- R10: Each exception output is high only in a cycle where `insn_bnd_i` is high, for one cycle per delivery.
- R11: A new reset or non-maskable request that arrives in the cycle its own flag is serviced keeps that flag held. The request is delivered again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset_i | input | 1 | Reset request pulse |
| req_nmi_i | input | 1 | Non-maskable request pulse |
| lvl_wr_i | input | 1 | Level word write strobe |
| lvl_data_i | input | 6 | Level word; zero marks end of interrupt |
| sr_ie_i | input | 1 | Global interrupt enable from status register |
| sr_mask_i | input | 6 | Interrupt mask from status register |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| cause_hwpend_o | output | 6 | Hardware-pending field for the cause register |
| exc_nmi_rst_o | output | 1 | Combined reset / non-maskable exception pulse |
| exc_int_o | output | 1 | Maskable interrupt exception pulse |

## Verification
The hardest state to reach is a level that is held but masked. It must survive several boundaries and then be taken only because the mask or enable changed, with no new write. The vector table reaches it by writing a level whose bits miss the mask and stepping boundaries with the enable off and then on. It then widens the mask and shows the interrupt fire. Two other corner cases get their own vectors. In the first, all three requests are held together and drained one per boundary while the cause field is watched. In the second, a non-maskable pulse lands in the very cycle its flag is serviced.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned LVL_W_DEF = 6;

  // State of the held level word
  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_SET  = 2'd1,
    LV_EOI  = 2'd2
  } lvl_state_e;

  // Indices of the single-bit request sources
  localparam int unsigned SRC_RST = 0;
  localparam int unsigned SRC_NMI = 1;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/irqd_req_flag.sv
module irqd_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  // A new request wins over a service in the same cycle
  always_comb begin
    pend_en = req_i | take_i;
    pend_d  = req_i | (pend_q & ~take_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r2_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !req_i) |=> !pend_o);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> pend_o);
endmodule

// File: rtl/irqd_level_track.sv
module irqd_level_track
  import irqd_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] data_i,
  input  logic             take_i,
  input  logic             fire_i,
  output lvl_state_e       state_o,
  output logic [LVL_W-1:0] val_o
);
  lvl_state_e       st_q, st_d;
  logic [LVL_W-1:0] val_q, val_d;
  logic             upd_en;

  always_comb begin
    st_d   = st_q;
    val_d  = val_q;
    upd_en = wr_i | take_i;
    if (wr_i) begin
      // Latest write replaces whatever is held
      val_d = data_i;
      st_d  = (data_i == '0) ? LV_EOI : LV_SET;
    end else if (take_i && ((st_q == LV_EOI) || fire_i)) begin
      st_d = LV_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LV_IDLE;
      val_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      val_q <= val_d;
    end
  end

  assign state_o = st_q;
  assign val_o   = val_q;

  a_r6_retry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LV_SET && take_i && !fire_i && !wr_i) |=> (st_q == LV_SET && val_q == $past(val_q)));
  a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (val_q == $past(data_i)));
  a_r4_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LV_EOI && take_i && !wr_i) |=> (st_q == LV_IDLE));
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
  import irqd_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic             bnd_i,
  input  logic             rst_pend_i,
  input  logic             nmi_pend_i,
  input  lvl_state_e       lvl_state_i,
  input  logic [LVL_W-1:0] lvl_val_i,
  input  logic             ie_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             take_rst_o,
  output logic             take_nmi_o,
  output logic             take_lvl_o,
  output logic             fire_int_o,
  output logic             eoi_o
);
  logic lvl_busy;
  logic unmasked;

  always_comb begin
    lvl_busy   = (lvl_state_i != LV_IDLE);
    unmasked   = |(lvl_val_i & mask_i);
    take_rst_o = bnd_i & rst_pend_i;
    take_nmi_o = bnd_i & ~rst_pend_i & nmi_pend_i;
    take_lvl_o = bnd_i & ~rst_pend_i & ~nmi_pend_i & lvl_busy;
    eoi_o      = (lvl_state_i == LV_EOI);
    fire_int_o = take_lvl_o & (lvl_state_i == LV_SET) & ie_i & unmasked;
  end
endmodule

// File: rtl/irq_delivery_unit.sv
module irq_delivery_unit
  import irqd_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_reset_i,
  input  logic             req_nmi_i,
  input  logic             lvl_wr_i,
  input  logic [LVL_W-1:0] lvl_data_i,
  input  logic             sr_ie_i,
  input  logic [LVL_W-1:0] sr_mask_i,
  input  logic             insn_bnd_i,
  output logic [LVL_W-1:0] cause_hwpend_o,
  output logic             exc_nmi_rst_o,
  output logic             exc_int_o
);
  logic [NUM_SRC-1:0] src_req;
  logic [NUM_SRC-1:0] src_take;
  logic [NUM_SRC-1:0] src_pend;
  lvl_state_e         lvl_state;
  logic [LVL_W-1:0]   lvl_val;
  logic               take_lvl;
  logic               fire_int;
  logic               eoi;
  logic [LVL_W-1:0]   cause_q, cause_d;
  logic               cause_en;

  assign src_req[SRC_RST] = req_reset_i;
  assign src_req[SRC_NMI] = req_nmi_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irqd_req_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (src_req[g]),
      .take_i (src_take[g]),
      .pend_o (src_pend[g])
    );
  end

  irqd_level_track #(.LVL_W(LVL_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (lvl_wr_i),
    .data_i  (lvl_data_i),
    .take_i  (take_lvl),
    .fire_i  (fire_int),
    .state_o (lvl_state),
    .val_o   (lvl_val)
  );

  irqd_arbiter #(.LVL_W(LVL_W)) u_arb (
    .bnd_i       (insn_bnd_i),
    .rst_pend_i  (src_pend[SRC_RST]),
    .nmi_pend_i  (src_pend[SRC_NMI]),
    .lvl_state_i (lvl_state),
    .lvl_val_i   (lvl_val),
    .ie_i        (sr_ie_i),
    .mask_i      (sr_mask_i),
    .take_rst_o  (src_take[SRC_RST]),
    .take_nmi_o  (src_take[SRC_NMI]),
    .take_lvl_o  (take_lvl),
    .fire_int_o  (fire_int),
    .eoi_o       (eoi)
  );

  // Cause pending field: cleared, then reloaded, on every level service
  always_comb begin
    cause_en = take_lvl;
    cause_d  = eoi ? '0 : lvl_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_hwpend_o = cause_q;
  assign exc_nmi_rst_o  = |src_take;
  assign exc_int_o      = fire_int;

  a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pend[SRC_RST] && insn_bnd_i) |-> (!exc_int_o && !take_lvl));
  a_r1_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    exc_nmi_rst_o |=> $stable(cause_hwpend_o));
  a_r3_cause_load: assert property (@(posedge clk) disable iff (!rst_n)
    (take_lvl && !eoi) |=> (cause_hwpend_o == $past(lvl_val)));
  a_r4_eoi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_lvl && eoi) |=> (cause_hwpend_o == '0));
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    exc_int_o |-> (sr_ie_i && |(cause_d & sr_mask_i)));
  a_r10_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_nmi_rst_o || exc_int_o) |-> insn_bnd_i);
endmodule

// File: tb/irq_delivery_unit_bench.sv
`timescale 1ns/1ps
module irq_delivery_unit_bench;
  typedef struct packed {
    logic [7:0] tag;
    logic       rr;
    logic       nr;
    logic       lw;
    logic [5:0] ld;
    logic       ie;
    logic [5:0] mk;
    logic       bd;
    logic       e_nr;
    logic       e_int;
    logic [5:0] e_cause;
  } vec_t;

  localparam int NV = 32;
  // Each row: inputs driven in one cycle, outputs expected in that same cycle
  localparam vec_t VECS [NV] = '{
    '{8'd7, 1'b0,1'b0,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b0,1'b0,6'h00}, // R7 nothing held
    '{8'd7, 1'b1,1'b0,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b0,1'b0,6'h00}, // R7 same-cycle boundary waits
    '{8'd7, 1'b0,1'b0,1'b0,6'h00,1'b0,6'h00,1'b0, 1'b0,1'b0,6'h00}, // R7 no boundary
    '{8'd2, 1'b0,1'b0,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b1,1'b0,6'h00}, // R2 reset delivered
    '{8'd2, 1'b0,1'b0,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b0,1'b0,6'h00}, // R2 flag cleared
    '{8'd5, 1'b0,1'b0,1'b1,6'h05,1'b1,6'h01,1'b0, 1'b0,1'b0,6'h00}, // write level 5
    '{8'd5, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h01,1'b1, 1'b0,1'b1,6'h00}, // R5 fires
    '{8'd3, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h01,1'b1, 1'b0,1'b0,6'h05}, // R3 cause=5, R5 cleared
    '{8'd6, 1'b0,1'b0,1'b1,6'h0A,1'b1,6'h01,1'b0, 1'b0,1'b0,6'h05}, // write level 0A
    '{8'd6, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h01,1'b1, 1'b0,1'b0,6'h05}, // R6 masked
    '{8'd3, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h01,1'b1, 1'b0,1'b0,6'h0A}, // R3 cause loaded while masked
    '{8'd5, 1'b0,1'b0,1'b0,6'h00,1'b0,6'h02,1'b1, 1'b0,1'b0,6'h0A}, // R5 enable off
    '{8'd10,1'b0,1'b0,1'b0,6'h00,1'b1,6'h02,1'b0, 1'b0,1'b0,6'h0A}, // R10 no boundary
    '{8'd6, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h02,1'b1, 1'b0,1'b1,6'h0A}, // R6 retry taken
    '{8'd5, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h02,1'b1, 1'b0,1'b0,6'h0A}, // R5 no longer held
    '{8'd4, 1'b0,1'b0,1'b1,6'h00,1'b1,6'h3F,1'b0, 1'b0,1'b0,6'h0A}, // write end-of-interrupt
    '{8'd4, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h3F,1'b1, 1'b0,1'b0,6'h0A}, // R4 no exception
    '{8'd4, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h3F,1'b1, 1'b0,1'b0,6'h00}, // R4 cause cleared, idle
    '{8'd1, 1'b1,1'b1,1'b1,6'h01,1'b1,6'h3F,1'b0, 1'b0,1'b0,6'h00}, // all three requests
    '{8'd1, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h3F,1'b1, 1'b1,1'b0,6'h00}, // R1 reset first
    '{8'd1, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h3F,1'b1, 1'b1,1'b0,6'h00}, // R1 then NMI, cause kept
    '{8'd1, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h3F,1'b1, 1'b0,1'b1,6'h00}, // R1 then level
    '{8'd3, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h3F,1'b1, 1'b0,1'b0,6'h01}, // R3 cause=1
    '{8'd8, 1'b0,1'b0,1'b1,6'h10,1'b1,6'h04,1'b0, 1'b0,1'b0,6'h01}, // write 10
    '{8'd8, 1'b0,1'b0,1'b1,6'h00,1'b1,6'h04,1'b0, 1'b0,1'b0,6'h01}, // overwrite with marker
    '{8'd8, 1'b0,1'b0,1'b1,6'h04,1'b1,6'h04,1'b0, 1'b0,1'b0,6'h01}, // overwrite marker with 4
    '{8'd8, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h04,1'b1, 1'b0,1'b1,6'h01}, // R8 last value fires
    '{8'd8, 1'b0,1'b0,1'b0,6'h00,1'b1,6'h04,1'b0, 1'b0,1'b0,6'h04}, // R8 cause=4
    '{8'd11,1'b0,1'b1,1'b0,6'h00,1'b0,6'h00,1'b0, 1'b0,1'b0,6'h04}, // NMI request
    '{8'd11,1'b0,1'b1,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b1,1'b0,6'h04}, // R11 service + new request
    '{8'd11,1'b0,1'b0,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b1,1'b0,6'h04}, // R11 delivered again
    '{8'd11,1'b0,1'b0,1'b0,6'h00,1'b0,6'h00,1'b1, 1'b0,1'b0,6'h04}  // R11 drained
  };

  logic       clk;
  logic       rst_n;
  logic       req_reset_i, req_nmi_i, lvl_wr_i, sr_ie_i, insn_bnd_i;
  logic [5:0] lvl_data_i, sr_mask_i, cause_hwpend_o;
  logic       exc_nmi_rst_o, exc_int_o;
  int         n_run;
  int         n_fail;

  irq_delivery_unit u_irq_delivery_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_reset_i    (req_reset_i),
    .req_nmi_i      (req_nmi_i),
    .lvl_wr_i       (lvl_wr_i),
    .lvl_data_i     (lvl_data_i),
    .sr_ie_i        (sr_ie_i),
    .sr_mask_i      (sr_mask_i),
    .insn_bnd_i     (insn_bnd_i),
    .cause_hwpend_o (cause_hwpend_o),
    .exc_nmi_rst_o  (exc_nmi_rst_o),
    .exc_int_o      (exc_int_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input int tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_reset_i = v.rr;
    req_nmi_i   = v.nr;
    lvl_wr_i    = v.lw;
    lvl_data_i  = v.ld;
    sr_ie_i     = v.ie;
    sr_mask_i   = v.mk;
    insn_bnd_i  = v.bd;
  endtask

  task automatic check_outs(input int tag, input logic enr, input logic eint, input logic [5:0] ec);
    chk(tag, "exc_nmi_rst_o", int'(exc_nmi_rst_o), int'(enr));
    chk(tag, "exc_int_o", int'(exc_int_o), int'(eint));
    chk(tag, "cause_hwpend_o", int'(cause_hwpend_o), int'(ec));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    drive('0);
    insn_bnd_i = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    check_outs(9, 1'b0, 1'b0, 6'h00);  // R9 reset state
    @(negedge clk);
    rst_n = 1'b1;
    drive('0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #5;
      check_outs(int'(VECS[i].tag), VECS[i].e_nr, VECS[i].e_int, VECS[i].e_cause);
    end

    // R9: held requests and cause are wiped by reset
    @(negedge clk);
    drive('0);
    req_reset_i = 1'b1;
    req_nmi_i   = 1'b1;
    lvl_wr_i    = 1'b1;
    lvl_data_i  = 6'h3F;
    @(negedge clk);
    drive('0);
    insn_bnd_i = 1'b1;
    sr_ie_i    = 1'b1;
    sr_mask_i  = 6'h3F;
    rst_n      = 1'b0;
    #5;
    check_outs(9, 1'b0, 1'b0, 6'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check_outs(9, 1'b0, 1'b0, 6'h00);  // R9 nothing survives reset
    @(negedge clk);
    #5;
    check_outs(9, 1'b0, 1'b0, 6'h00);

    drive('0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule